// File: doc/BRIEF.md
# Dual-Output Power-Up Sequencer

This block decides when each of two converter outputs may start switching. It waits for the input supply to clear its undervoltage check. It turns on the bias regulator when at least one of the two active-low enables is asserted. Once the bias supply reports ready, it issues a run request per channel. A two-bit order code is captured once per power-on and selects one of three modes:

- Output 1 leads and output 2 follows.
- Output 2 leads and output 1 follows.
- Both channels run freely.

In the two ordered modes, the following channel ignores its own enable. It starts a fixed number of clock ticks after the leading channel is running and reports regulation. Releasing the leading enable stops both channels on the same clock edge.

All outputs are registered. A run request is what the downstream soft-start and PWM logic waits for. Dropping it turns that channel's switch off. No pulldown is driven from here, so the output simply decays.

Top module: `dual_out_sequencer`

## Requirements
- R1: While `uvlo_ok` is low, `bias_en`, `run1` and `run2` are all low from the next clock edge onward, whatever the enables do.
- R2: One edge after a cycle with `uvlo_ok` high and either `en1_n` or `en2_n` low, `bias_en` is high. The mode has no effect on this.
- R3: A run output can rise only on an edge where, in the cycle before, `bias_ok` was high and `bias_en` was already high. Dropping `bias_ok` clears both run outputs on the next edge.
- R4: With `en1_n` and `en2_n` both high, `bias_en` is low after the next edge, and the bias regulator stays off.
- R5: `mode_code` is captured on the first edge at which `uvlo_ok` is seen high. The captured value is kept until `uvlo_ok` falls, and later changes of `mode_code` have no effect. Encoding: 2'b00 means output 1 leads, 2'b11 means output 2 leads, and 2'b01 or 2'b10 means free running.
- R6: In an ordered mode, the following channel's run rises on the DELAY_TICKS-th consecutive edge at which the leading channel's run and its regulation flag (`reg1_ok` or `reg2_ok`) are both high. A break in either one restarts the count.
- R7: In an ordered mode, the following channel's enable has no effect. That channel neither starts without the leading channel nor is held off by its own enable.
- R8: In an ordered mode, releasing the leading channel's enable clears both run outputs on the same edge.
- R9: In free-running mode, each run output follows its own enable. With the bias already ready, asserting an enable raises that run on the next edge.
- R10: Releasing a channel's enable clears its own run on the next edge and leaves the other free-running channel untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo_ok | input | 1 | Input supply is above its undervoltage threshold |
| bias_ok | input | 1 | Bias supply has reached its ready threshold |
| en1_n | input | 1 | Active-low enable for output 1 |
| en2_n | input | 1 | Active-low enable for output 2 |
| mode_code | input | 2 | Order code: 00 output 1 leads, 11 output 2 leads, otherwise free |
| reg1_ok | input | 1 | Output 1 has reached regulation |
| reg2_ok | input | 1 | Output 2 has reached regulation |
| bias_en | output | 1 | Turns the bias regulator on |
| run1 | output | 1 | Start/run request for output 1 |
| run2 | output | 1 | Start/run request for output 2 |

## Verification
The embedded assertions check the following on every cycle:
- The supply gate clears everything.
- The bias regulator is off when neither enable is asserted.
- No run rises without a ready bias.
- The captured order stays stable while the supply holds.
- A follower never runs without its leader, and it only starts after seeing the leader running and in regulation.
- The delay count never passes its limit.

Some properties are visible only from the bench's scenarios, which a lockstep behavioural model compares on every clock:
- The exact tick on which the follower starts, and the restart of the count when regulation blips.
- That a late change of the order code is ignored.
- That an ignored follower enable really has no effect.
- That in free mode one channel can be released without disturbing the other.

// File: rtl/dos_pkg.sv
package dos_pkg;

   typedef enum logic [1:0] {
      ORDER_FREE      = 2'd0,
      ORDER_ONE_FIRST = 2'd1,
      ORDER_TWO_FIRST = 2'd2
   } order_e;

   typedef enum logic [1:0] {
      ROLE_SOLO   = 2'd0,
      ROLE_LEAD   = 2'd1,
      ROLE_FOLLOW = 2'd2
   } role_e;

   function automatic order_e decode_order(input logic [1:0] code);
      case (code)
         2'b00:   decode_order = ORDER_ONE_FIRST;
         2'b11:   decode_order = ORDER_TWO_FIRST;
         default: decode_order = ORDER_FREE;
      endcase
   endfunction

   function automatic role_e role_of(input order_e order, input int unsigned chan);
      if (order == ORDER_FREE)
         role_of = ROLE_SOLO;
      else if ((order == ORDER_ONE_FIRST) == (chan == 0))
         role_of = ROLE_LEAD;
      else
         role_of = ROLE_FOLLOW;
   endfunction

endpackage

// File: rtl/dos_mode_latch.sv
module dos_mode_latch
   import dos_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       uvlo_ok,
   input  logic [1:0] mode_code,
   output logic       captured,
   output order_e     order
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         captured <= 1'b0;
         order    <= ORDER_FREE;
      end else if (!uvlo_ok) begin
         captured <= 1'b0;
      end else if (!captured) begin
         captured <= 1'b1;
         order    <= decode_order(mode_code);
      end
   end

   // R5
   order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (captured && uvlo_ok) |=> $stable(order));

   // R5
   capture_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !uvlo_ok |=> !captured);

endmodule

// File: rtl/dos_bias_gate.sv
module dos_bias_gate #(
   parameter int unsigned NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              uvlo_ok,
   input  logic              bias_ok,
   input  logic              captured,
   input  logic [NUM_CH-1:0] en_req,
   output logic              bias_en,
   output logic              ready
);

   generate
      if (NUM_CH < 1) begin : g_bad_count
         $error("dos_bias_gate: NUM_CH must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bias_en <= 1'b0;
      else        bias_en <= uvlo_ok && (|en_req);
   end

   assign ready = uvlo_ok && captured && bias_en && bias_ok;

   // R4
   bias_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_req == '0) |=> !bias_en);

   // R1
   bias_uvlo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !uvlo_ok |=> !bias_en);

endmodule

// File: rtl/dos_chan_ctl.sv
module dos_chan_ctl
   import dos_pkg::*;
#(
   parameter int unsigned DELAY_TICKS = 40000
) (
   input  logic  clk,
   input  logic  rst_n,
   input  role_e role,
   input  logic  ready,
   input  logic  own_req,
   input  logic  lead_req,
   input  logic  lead_run,
   input  logic  lead_reg,
   output logic  run
);

   localparam int unsigned CNT_W = (DELAY_TICKS < 2) ? 1 : $clog2(DELAY_TICKS + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_TICKS - 1);

   generate
      if (DELAY_TICKS < 1) begin : g_bad_delay
         $error("dos_chan_ctl: DELAY_TICKS must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             lead_alive;
   logic             lead_settled;
   logic             hit;

   assign lead_alive   = ready && lead_req;
   assign lead_settled = lead_run && lead_reg;

   generate
      if (DELAY_TICKS == 1) begin : g_no_wait
         assign hit = 1'b1;
      end else begin : g_wait
         assign hit = (cnt == LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         cnt <= '0;
      end else if (role == ROLE_FOLLOW) begin
         if (!lead_alive) begin
            run <= 1'b0;
            cnt <= '0;
         end else if (!run) begin
            if (lead_settled) begin
               if (hit) run <= 1'b1;
               else     cnt <= cnt + 1'b1;
            end else begin
               cnt <= '0;
            end
         end
      end else begin
         run <= ready && own_req;
         cnt <= '0;
      end
   end

   // R8
   follow_needs_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (role == ROLE_FOLLOW && run) |-> lead_run);

   // R6
   follow_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (role == ROLE_FOLLOW && $rose(run)) |-> $past(lead_run && lead_reg));

   // R6
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);

endmodule

// File: rtl/dual_out_sequencer.sv
module dual_out_sequencer
   import dos_pkg::*;
#(
   parameter int unsigned DELAY_TICKS = 40000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       uvlo_ok,
   input  logic       bias_ok,
   input  logic       en1_n,
   input  logic       en2_n,
   input  logic [1:0] mode_code,
   input  logic       reg1_ok,
   input  logic       reg2_ok,
   output logic       bias_en,
   output logic       run1,
   output logic       run2
);

   localparam int unsigned NUM_CH = 2;

   logic              captured;
   order_e            order;
   logic              ready;
   logic [NUM_CH-1:0] en_req;
   logic [NUM_CH-1:0] reg_ok;
   logic [NUM_CH-1:0] run;

   assign en_req = {~en2_n, ~en1_n};
   assign reg_ok = {reg2_ok, reg1_ok};

   dos_mode_latch i_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .uvlo_ok   (uvlo_ok),
      .mode_code (mode_code),
      .captured  (captured),
      .order     (order)
   );

   dos_bias_gate #(.NUM_CH(NUM_CH)) i_bias (
      .clk      (clk),
      .rst_n    (rst_n),
      .uvlo_ok  (uvlo_ok),
      .bias_ok  (bias_ok),
      .captured (captured),
      .en_req   (en_req),
      .bias_en  (bias_en),
      .ready    (ready)
   );

   generate
      for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
         localparam int unsigned PEER = NUM_CH - 1 - k;
         role_e role;
         assign role = role_of(order, k);

         dos_chan_ctl #(.DELAY_TICKS(DELAY_TICKS)) i_ctl (
            .clk      (clk),
            .rst_n    (rst_n),
            .role     (role),
            .ready    (ready),
            .own_req  (en_req[k]),
            .lead_req (en_req[PEER]),
            .lead_run (run[PEER]),
            .lead_reg (reg_ok[PEER]),
            .run      (run[k])
         );

         // R3
         run_needs_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(run[k]) |-> $past(bias_ok && bias_en));
      end
   endgenerate

   assign run1 = run[0];
   assign run2 = run[1];

   // R1
   run_uvlo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !uvlo_ok |=> (run == '0));

endmodule

// File: tb/test_dual_out_sequencer.sv
module test_dual_out_sequencer;

   localparam int CLK_PERIOD = 10;
   localparam int DLY        = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       uvlo_ok = 1'b0, bias_ok = 1'b0;
   logic       en1_n = 1'b1, en2_n = 1'b1;
   logic [1:0] mode_code = 2'b00;
   logic       reg1_ok = 1'b0, reg2_ok = 1'b0;
   logic       bias_en, run1, run2;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_out_sequencer #(.DELAY_TICKS(DLY)) i_dual_out_sequencer (
      .clk(clk), .rst_n(rst_n), .uvlo_ok(uvlo_ok), .bias_ok(bias_ok),
      .en1_n(en1_n), .en2_n(en2_n), .mode_code(mode_code),
      .reg1_ok(reg1_ok), .reg2_ok(reg2_ok),
      .bias_en(bias_en), .run1(run1), .run2(run2)
   );

   // Behavioural reference: ord 0 free, 1 output 1 leads, 2 output 2 leads
   bit m_bias, m_latched;
   bit m_run [2];
   int m_cnt [2];
   int m_ord;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_bias = 0; m_latched = 0; m_ord = 0;
         m_run[0] = 0; m_run[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
      end else begin
         bit rdy;
         bit en [2];
         bit rg [2];
         bit nrun [2];
         en[0] = !en1_n; en[1] = !en2_n;
         rg[0] = reg1_ok; rg[1] = reg2_ok;
         rdy = uvlo_ok && m_latched && m_bias && bias_ok;
         for (int c = 0; c < 2; c++) begin
            int ld;
            ld = 1 - c;
            if (m_ord == 0 || m_ord == c + 1) begin
               nrun[c] = rdy && en[c];
               m_cnt[c] = 0;
            end else if (!(rdy && en[ld])) begin
               nrun[c] = 0; m_cnt[c] = 0;
            end else if (m_run[c]) begin
               nrun[c] = 1;
            end else if (m_run[ld] && rg[ld]) begin
               m_cnt[c] = m_cnt[c] + 1;
               nrun[c] = (m_cnt[c] >= DLY);
            end else begin
               nrun[c] = 0; m_cnt[c] = 0;
            end
         end
         m_run[0] = nrun[0]; m_run[1] = nrun[1];
         m_bias = uvlo_ok && (en[0] || en[1]);
         if (!uvlo_ok) m_latched = 0;
         else if (!m_latched) begin
            m_latched = 1;
            m_ord = (mode_code == 2'b00) ? 1 : (mode_code == 2'b11) ? 2 : 0;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks += 3;
         if (bias_en !== m_bias) begin
            errors++;
            $display("FAIL R2 model bias_en actual %0b expected %0b @%0t", bias_en, m_bias, $time);
         end
         if (run1 !== m_run[0]) begin
            errors++;
            $display("FAIL R6/R9 model run1 actual %0b expected %0b @%0t", run1, m_run[0], $time);
         end
         if (run2 !== m_run[1]) begin
            errors++;
            $display("FAIL R6/R9 model run2 actual %0b expected %0b @%0t", run2, m_run[1], $time);
         end
      end
   end

   task automatic chk(input string req, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %0b expected %0b @%0t", req, what, act, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired actual running expected finished");
      finish_run();
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      chk("R1", bias_en, 1'b0, "reset bias_en");
      chk("R1", run1 | run2, 1'b0, "reset runs");

      // R1: supply low, enables asserted
      en1_n = 0; en2_n = 0; cyc(3);
      chk("R1", bias_en, 1'b0, "uvlo low bias_en");
      chk("R1", run1 | run2, 1'b0, "uvlo low runs");

      // Output 1 leads, follower enable released (R7)
      en2_n = 1; mode_code = 2'b00; uvlo_ok = 1; bias_ok = 1; cyc(1);
      chk("R2", bias_en, 1'b1, "bias_en after uvlo");
      cyc(2);
      chk("R6", run1, 1'b1, "leader run1");
      chk("R6", run2, 1'b0, "follower waits");
      mode_code = 2'b11; reg1_ok = 1; cyc(DLY-1);
      chk("R6", run2, 1'b0, "follower one tick early");
      cyc(1);
      chk("R6", run2, 1'b1, "follower at delay");
      chk("R7", run2, 1'b1, "follower enable ignored");
      cyc(3);
      chk("R5", run1 & run2, 1'b1, "late code change ignored");
      en2_n = 0; cyc(2); en2_n = 1; cyc(2);
      chk("R7", run2, 1'b1, "follower enable toggle ignored");
      en1_n = 1; cyc(1);
      chk("R8", run1 | run2, 1'b0, "leader release stops both");
      chk("R4", bias_en, 1'b0, "bias off with both enables high");

      // R6 count restart
      en1_n = 0; reg1_ok = 0; cyc(3);
      chk("R6", run1, 1'b1, "leader restarts");
      reg1_ok = 1; cyc(5); reg1_ok = 0; cyc(1); reg1_ok = 1; cyc(DLY-1);
      chk("R6", run2, 1'b0, "count restarted after blip");
      cyc(1);
      chk("R6", run2, 1'b1, "follower after full count");

      // Output 2 leads
      uvlo_ok = 0; reg1_ok = 0; cyc(1);
      chk("R1", bias_en | run1 | run2, 1'b0, "supply loss clears all");
      cyc(1); uvlo_ok = 1; en1_n = 0; en2_n = 1; cyc(4);
      chk("R2", bias_en, 1'b1, "bias on with follower enable");
      chk("R7", run1, 1'b0, "follower not started alone");
      chk("R7", run2, 1'b0, "leader off");
      en2_n = 0; cyc(1);
      chk("R6", run2, 1'b1, "leader 2 immediate");
      chk("R6", run1, 1'b0, "follower 1 waits");
      reg2_ok = 1; cyc(DLY);
      chk("R6", run1, 1'b1, "follower 1 after delay");
      en2_n = 1; cyc(1);
      chk("R8", run1 | run2, 1'b0, "leader 2 release stops both");

      // Free running
      uvlo_ok = 0; reg2_ok = 0; en1_n = 1; en2_n = 1; cyc(2);
      mode_code = 2'b01; uvlo_ok = 1; cyc(3);
      chk("R4", bias_en, 1'b0, "idle bias off");
      en1_n = 0; cyc(1);
      chk("R3", run1, 1'b0, "no run before bias_en");
      cyc(1);
      chk("R9", run1, 1'b1, "free run1");
      chk("R9", run2, 1'b0, "free run2 idle");
      en2_n = 0; cyc(1);
      chk("R9", run2, 1'b1, "free run2 immediate");
      en1_n = 1; cyc(1);
      chk("R10", run1, 1'b0, "run1 released");
      chk("R10", run2, 1'b1, "run2 untouched");

      // Bias readiness
      bias_ok = 0; cyc(1);
      chk("R3", run2, 1'b0, "bias loss stops run2");
      en1_n = 0; cyc(3);
      chk("R3", run1 | run2, 1'b0, "no run without bias_ok");
      chk("R2", bias_en, 1'b1, "bias_en still requested");
      bias_ok = 1; cyc(1);
      chk("R3", run1 & run2, 1'b1, "runs after bias_ok");
      mode_code = 2'b00; cyc(3);
      chk("R5", run1 & run2, 1'b1, "free mode kept while supply holds");

      cyc(2);
      finish_run();
   end

endmodule